// File: doc/BRIEF.md
# Packet Tag Byte Override Unit

This unit rewrites the two 16-bit tags that go into a receive packet descriptor: the source tag and the destination tag. Each tag is split into a high byte (bits 15:8) and a low byte (bits 7:0). Each of the four bytes has its own 3-bit selector and its own 8-bit constant, both taken from the flow configuration.

For every byte the selector picks one of four sources: the byte as it arrived, the byte's constant, the low byte of the packet's flow ID, or a byte of the tag that came with the packet. The rewritten tags are registered one clock after a valid strobe.

Selector codes that have no defined meaning leave the byte as it arrived. They also set a sticky configuration-error flag, which only reset clears. The unit does not write descriptors and has no register access. Its selectors and constants are plain inputs driven by the flow configuration.

Top module: `tag_ovr_unit`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, both output tags are 0x0000 and `cfg_err` is 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is 0, the output tags keep their previous values whatever the other inputs do.
- R3: Selector code 0 leaves the byte equal to the same byte of the incoming tag. The source bytes come from `in_src_tag`, the destination bytes from `in_dst_tag`.
- R4: Selector code 1 replaces the byte with that byte's 8-bit constant input.
- R5: Selector code 2 replaces the byte with `in_flow_lo`, the flow ID bits 7:0.
- R6: On either source-tag byte, selector code 4 substitutes `in_src_tag[7:0]`.
- R7: On either destination-tag byte, code 4 substitutes `in_dst_tag[7:0]` and code 5 substitutes `in_dst_tag[15:8]`.
- R8: Reserved codes leave the byte unchanged, as code 0 does. The reserved codes are 3, 5, 6 and 7 for source bytes and 3, 6 and 7 for destination bytes.
- R9: `cfg_err` goes to 1 in the same cycle that `out_valid` shows a packet strobed with any reserved selector. It stays 1 until reset. A reserved selector present while `in_valid` is 0 does not set it.
- R10: Each byte is selected independently. The high-byte result sits in tag bits 15:8 and the low-byte result in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming tags and flow ID are valid this cycle |
| in_src_tag | input | 16 | Source tag supplied with the packet |
| in_dst_tag | input | 16 | Destination tag supplied with the packet |
| in_flow_lo | input | 8 | Flow ID bits 7:0 supplied with the packet |
| sel_src_hi | input | 3 | Selector for source tag bits 15:8 |
| sel_src_lo | input | 3 | Selector for source tag bits 7:0 |
| sel_dst_hi | input | 3 | Selector for destination tag bits 15:8 |
| sel_dst_lo | input | 3 | Selector for destination tag bits 7:0 |
| cst_src_hi | input | 8 | Constant for source tag bits 15:8 |
| cst_src_lo | input | 8 | Constant for source tag bits 7:0 |
| cst_dst_hi | input | 8 | Constant for destination tag bits 15:8 |
| cst_dst_lo | input | 8 | Constant for destination tag bits 7:0 |
| out_valid | output | 1 | Registered tags are valid |
| out_src_tag | output | 16 | Rewritten source tag |
| out_dst_tag | output | 16 | Rewritten destination tag |
| cfg_err | output | 1 | Sticky flag: a reserved selector was used |

## Verification
The assertions compare each output byte with the previous cycle's inputs using `$past`. They therefore assume that selectors, constants, tags and flow ID are sampled only on the clock edge and change at most once per cycle. The stimulus meets this by changing every input on the falling edge only. Configuration is normally static while traffic flows, but the assertions do not assume that. The stimulus deliberately changes selectors and constants between strobes, and also while `in_valid` is low, so the hold and no-error behaviour is exercised as well.

// File: rtl/tag_ovr_pkg.sv
package tag_ovr_pkg;

    localparam int SEL_W = 3;

    // Selector encodings shared by all four tag bytes
    typedef enum logic [SEL_W-1:0] {
        SEL_KEEP   = 3'd0,
        SEL_CONST  = 3'd1,
        SEL_FLOW   = 3'd2,
        SEL_RSV3   = 3'd3,
        SEL_TAG_LO = 3'd4,
        SEL_TAG_HI = 3'd5,
        SEL_RSV6   = 3'd6,
        SEL_RSV7   = 3'd7
    } tag_sel_e;

    // Code 5 is only meaningful on destination bytes
    function automatic logic sel_is_reserved(input logic [SEL_W-1:0] sel, input logic is_dst);
        logic rsv;
        case (sel)
            SEL_KEEP, SEL_CONST, SEL_FLOW, SEL_TAG_LO: rsv = 1'b0;
            SEL_TAG_HI:                                rsv = !is_dst;
            default:                                   rsv = 1'b1;
        endcase
        return rsv;
    endfunction

endpackage

// File: rtl/tag_byte_sel.sv
module tag_byte_sel
    import tag_ovr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int TAG_W  = 16,
    parameter bit IS_DST = 1'b0,
    parameter bit HI     = 1'b0
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] cnst,
    input  logic [BYTE_W-1:0] flow,
    input  logic [TAG_W-1:0]  tag,
    output logic [BYTE_W-1:0] byte_o,
    output logic              rsv_o
);

    localparam int KEEP_LSB = HI ? BYTE_W : 0;

    logic [BYTE_W-1:0] keep_b;
    logic [BYTE_W-1:0] tag_lo_b;
    logic [BYTE_W-1:0] tag_hi_b;

    assign keep_b   = tag[KEEP_LSB +: BYTE_W];
    assign tag_lo_b = tag[0 +: BYTE_W];
    assign tag_hi_b = tag[BYTE_W +: BYTE_W];

    always_comb begin
        rsv_o  = sel_is_reserved(sel, IS_DST);
        byte_o = keep_b;
        if (!rsv_o) begin
            case (sel)
                SEL_CONST:  byte_o = cnst;
                SEL_FLOW:   byte_o = flow;
                SEL_TAG_LO: byte_o = tag_lo_b;
                SEL_TAG_HI: byte_o = tag_hi_b;
                default:    byte_o = keep_b;
            endcase
        end
    end

endmodule

// File: rtl/tag_ovr_unit.sv
module tag_ovr_unit
    import tag_ovr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int TAG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_src_tag,
    input  logic [TAG_W-1:0]  in_dst_tag,
    input  logic [BYTE_W-1:0] in_flow_lo,
    input  logic [SEL_W-1:0]  sel_src_hi,
    input  logic [SEL_W-1:0]  sel_src_lo,
    input  logic [SEL_W-1:0]  sel_dst_hi,
    input  logic [SEL_W-1:0]  sel_dst_lo,
    input  logic [BYTE_W-1:0] cst_src_hi,
    input  logic [BYTE_W-1:0] cst_src_lo,
    input  logic [BYTE_W-1:0] cst_dst_hi,
    input  logic [BYTE_W-1:0] cst_dst_lo,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_src_tag,
    output logic [TAG_W-1:0]  out_dst_tag,
    output logic              cfg_err
);

    localparam int BYTES_PER_TAG = TAG_W / BYTE_W;
    localparam int NBYTES        = 2 * BYTES_PER_TAG;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] src;
        logic [TAG_W-1:0] dst;
        logic             err;
    } state_t;

    // Byte slots: 0 src lo, 1 src hi, 2 dst lo, 3 dst hi
    logic [NBYTES-1:0][SEL_W-1:0]  sel_v;
    logic [NBYTES-1:0][BYTE_W-1:0] cst_v;
    logic [NBYTES-1:0][BYTE_W-1:0] byte_w;
    logic [NBYTES-1:0]             rsv_w;

    assign sel_v = {sel_dst_hi, sel_dst_lo, sel_src_hi, sel_src_lo};
    assign cst_v = {cst_dst_hi, cst_dst_lo, cst_src_hi, cst_src_lo};

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_byte
            localparam bit G_DST = (g >= BYTES_PER_TAG);
            localparam bit G_HI  = ((g % BYTES_PER_TAG) == 1);
            logic [TAG_W-1:0] tag_in;
            assign tag_in = G_DST ? in_dst_tag : in_src_tag;
            tag_byte_sel #(
                .BYTE_W (BYTE_W),
                .TAG_W  (TAG_W),
                .IS_DST (G_DST),
                .HI     (G_HI)
            ) u_sel (
                .sel    (sel_v[g]),
                .cnst   (cst_v[g]),
                .flow   (in_flow_lo),
                .tag    (tag_in),
                .byte_o (byte_w[g]),
                .rsv_o  (rsv_w[g])
            );
        end
    endgenerate

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.src = byte_w[BYTES_PER_TAG-1:0];
            st_d.dst = byte_w[NBYTES-1:BYTES_PER_TAG];
            st_d.err = st_q.err | (|rsv_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_src_tag = st_q.src;
    assign out_dst_tag = st_q.dst;
    assign cfg_err     = st_q.err;

endmodule

// File: rtl/tag_ovr_chk.sv
module tag_ovr_chk #(
    parameter int BYTE_W = 8,
    parameter int TAG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [TAG_W-1:0]  in_src_tag,
    input logic [TAG_W-1:0]  in_dst_tag,
    input logic [BYTE_W-1:0] in_flow_lo,
    input logic [2:0]        sel_src_hi,
    input logic [2:0]        sel_src_lo,
    input logic [2:0]        sel_dst_hi,
    input logic [2:0]        sel_dst_lo,
    input logic [BYTE_W-1:0] cst_src_hi,
    input logic              out_valid,
    input logic [TAG_W-1:0]  out_src_tag,
    input logic [TAG_W-1:0]  out_dst_tag,
    input logic              cfg_err
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_tags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_src_tag) && $stable(out_dst_tag)));

    assert_keep_src_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_src_hi == 3'd0) |=> out_src_tag[TAG_W-1:BYTE_W] == $past(in_src_tag[TAG_W-1:BYTE_W]));

    assert_keep_dst_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_dst_lo == 3'd0) |=> out_dst_tag[BYTE_W-1:0] == $past(in_dst_tag[BYTE_W-1:0]));

    assert_const_src_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_src_hi == 3'd1) |=> out_src_tag[TAG_W-1:BYTE_W] == $past(cst_src_hi));

    assert_flow_src_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_src_lo == 3'd2) |=> out_src_tag[BYTE_W-1:0] == $past(in_flow_lo));

    assert_src_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_src_hi == 3'd4) |=> out_src_tag[TAG_W-1:BYTE_W] == $past(in_src_tag[BYTE_W-1:0]));

    assert_dst_hi_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_dst_hi == 3'd5) |=> out_dst_tag[TAG_W-1:BYTE_W] == $past(in_dst_tag[TAG_W-1:BYTE_W]));

    assert_rsv_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_src_lo == 3'd5) |=> out_src_tag[BYTE_W-1:0] == $past(in_src_tag[BYTE_W-1:0]));

    assert_rsv_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_dst_hi == 3'd6) |=> cfg_err);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_err && !in_valid) |=> !cfg_err);

endmodule

bind tag_ovr_unit tag_ovr_chk #(
    .BYTE_W (BYTE_W),
    .TAG_W  (TAG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_src_tag  (in_src_tag),
    .in_dst_tag  (in_dst_tag),
    .in_flow_lo  (in_flow_lo),
    .sel_src_hi  (sel_src_hi),
    .sel_src_lo  (sel_src_lo),
    .sel_dst_hi  (sel_dst_hi),
    .sel_dst_lo  (sel_dst_lo),
    .cst_src_hi  (cst_src_hi),
    .out_valid   (out_valid),
    .out_src_tag (out_src_tag),
    .out_dst_tag (out_dst_tag),
    .cfg_err     (cfg_err)
);

// File: tb/tag_ovr_unit_test.sv
module tag_ovr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_src_tag = '0;
    logic [15:0] in_dst_tag = '0;
    logic [7:0]  in_flow_lo = '0;
    logic [2:0]  sel_src_hi = '0, sel_src_lo = '0, sel_dst_hi = '0, sel_dst_lo = '0;
    logic [7:0]  cst_src_hi = '0, cst_src_lo = '0, cst_dst_hi = '0, cst_dst_lo = '0;
    logic        out_valid;
    logic [15:0] out_src_tag, out_dst_tag;
    logic        cfg_err;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // 125 MHz: 8 ns period
    always #4 clk = ~clk;

    tag_ovr_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_src_tag(in_src_tag), .in_dst_tag(in_dst_tag), .in_flow_lo(in_flow_lo),
        .sel_src_hi(sel_src_hi), .sel_src_lo(sel_src_lo),
        .sel_dst_hi(sel_dst_hi), .sel_dst_lo(sel_dst_lo),
        .cst_src_hi(cst_src_hi), .cst_src_lo(cst_src_lo),
        .cst_dst_hi(cst_dst_hi), .cst_dst_lo(cst_dst_lo),
        .out_valid(out_valid), .out_src_tag(out_src_tag),
        .out_dst_tag(out_dst_tag), .cfg_err(cfg_err)
    );

    // Reference model, written from the requirements
    logic        m_vld = 1'b0;
    logic [15:0] m_src = '0;
    logic [15:0] m_dst = '0;
    logic        m_err = 1'b0;

    function automatic logic [7:0] ref_byte(input int sel, input bit dst, input logic [7:0] c,
                                            input logic [7:0] f, input logic [15:0] t, input bit hi);
        logic [7:0] keep = hi ? t[15:8] : t[7:0];
        if (sel == 1) return c;
        if (sel == 2) return f;
        if (sel == 4) return t[7:0];
        if (sel == 5 && dst) return t[15:8];
        return keep;
    endfunction

    function automatic bit ref_rsv(input int sel, input bit dst);
        return (sel == 3) || (sel >= 6) || (sel == 5 && !dst);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_vld = 1'b0; m_src = '0; m_dst = '0; m_err = 1'b0;
        end else begin
            m_vld = in_valid;
            if (in_valid) begin
                m_src = {ref_byte(sel_src_hi, 0, cst_src_hi, in_flow_lo, in_src_tag, 1),
                         ref_byte(sel_src_lo, 0, cst_src_lo, in_flow_lo, in_src_tag, 0)};
                m_dst = {ref_byte(sel_dst_hi, 1, cst_dst_hi, in_flow_lo, in_dst_tag, 1),
                         ref_byte(sel_dst_lo, 1, cst_dst_lo, in_flow_lo, in_dst_tag, 0)};
                if (ref_rsv(sel_src_hi, 0) || ref_rsv(sel_src_lo, 0) ||
                    ref_rsv(sel_dst_hi, 1) || ref_rsv(sel_dst_lo, 1))
                    m_err = 1'b1;
            end
        end
    end

    task automatic check1(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        check1("out_valid",   {15'd0, out_valid}, {15'd0, m_vld});
        check1("out_src_tag", out_src_tag, m_src);
        check1("out_dst_tag", out_dst_tag, m_dst);
        if (cur_req == "R8") check1("cfg_err", {15'd0, cfg_err}, {15'd0, m_err});
        else check1("cfg_err", {15'd0, cfg_err}, {15'd0, m_err});
    end

    task automatic rand_pkt(input bit v);
        @(negedge clk);
        #1;
        in_valid   = v;
        in_src_tag = 16'($urandom);
        in_dst_tag = 16'($urandom);
        in_flow_lo = 8'($urandom);
        cst_src_hi = 8'($urandom);
        cst_src_lo = 8'($urandom);
        cst_dst_hi = 8'($urandom);
        cst_dst_lo = 8'($urandom);
    endtask

    task automatic set_sel(input logic [2:0] sh, input logic [2:0] sl,
                           input logic [2:0] dh, input logic [2:0] dl);
        @(negedge clk);
        #1;
        sel_src_hi = sh; sel_src_lo = sl; sel_dst_hi = dh; sel_dst_lo = dl;
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) rand_pkt(1'b1);
        rand_pkt(1'b0);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: pass-through on code 0
        cur_req = "R3";
        set_sel(3'd0, 3'd0, 3'd0, 3'd0);
        burst(6);

        // R4: constants on every byte
        cur_req = "R4";
        set_sel(3'd1, 3'd1, 3'd1, 3'd1);
        burst(6);

        // R5: flow ID byte everywhere
        cur_req = "R5";
        set_sel(3'd2, 3'd2, 3'd2, 3'd2);
        burst(6);

        // R6: source bytes take incoming source tag low byte
        cur_req = "R6";
        set_sel(3'd4, 3'd4, 3'd0, 3'd0);
        burst(6);

        // R7: destination bytes swapped via codes 4 and 5
        cur_req = "R7";
        set_sel(3'd0, 3'd0, 3'd4, 3'd5);
        burst(6);

        // R10: independent selection per byte
        cur_req = "R10";
        set_sel(3'd1, 3'd4, 3'd5, 3'd2);
        burst(6);
        set_sel(3'd2, 3'd1, 3'd0, 3'd4);
        burst(6);

        // R2: gaps in valid, inputs changing while idle
        cur_req = "R2";
        for (int i = 0; i < 20; i++) rand_pkt(($urandom % 3) == 0);
        rand_pkt(1'b0);

        // R9: reserved selectors without valid must not flag
        cur_req = "R9";
        set_sel(3'd7, 3'd5, 3'd6, 3'd3);
        for (int i = 0; i < 5; i++) rand_pkt(1'b0);

        // R8: reserved codes act as keep and set the flag
        cur_req = "R8";
        set_sel(3'd3, 3'd5, 3'd0, 3'd0);
        burst(3);
        set_sel(3'd6, 3'd7, 3'd3, 3'd7);
        burst(3);

        // R9: flag stays set with legal selectors
        cur_req = "R9";
        set_sel(3'd1, 3'd2, 3'd5, 3'd4);
        burst(6);

        // R1: reset clears the flag again, and dst code 5 does not flag
        cur_req = "R1";
        @(negedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R7";
        set_sel(3'd0, 3'd0, 3'd5, 3'd5);
        burst(4);

        repeat (2) @(negedge clk);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule